// File: doc/BRIEF.md
# Host Register Bank with Interrupt Outputs

This block is the host-facing register file of a bus arbitration controller. A host CPU reaches sixteen 8-bit locations through a chip select, a read/write line, a 4-bit address and a data acknowledge. The locations hold the transmit competition numbers, the outgoing message word and three control words. The host can also read the received competition numbers and message, the sequencer state, a sticky error status word, a fixed all-ones message word and a revision code. Three locations exist only to clear the three interrupt outputs. All host inputs are taken to be synchronous to `clk`. Chip select must go low for at least one cycle between accesses.

The arbitration sequencer next to this block reports events through a few inputs: error flags, and a one-cycle pulse that comes with a received number pair and message. The bank latches these, raises the error, message and power-fail interrupts, and pulses a strobe so that an external FIFO can keep each received message. It also provides odd parity for each of the two transmit competition numbers. A mode input picks when a host write takes effect. With it at 0 the write lands as the acknowledge rises. With it at 1 the write lands when the host drops chip select.

Top module: `hbank_regs`

## Requirements
- R1: `host_ack` goes to 1 on the first clock edge at which `host_cs` is sampled high, and back to 0 on the first edge at which `host_cs` is sampled low.
- R2: With `wr_edge_sel`=0, a write (`host_rd`=0) updates the addressed register on the same edge at which `host_ack` rises, using the address and data present then.
- R3: With `wr_edge_sel`=1, a write leaves the register unchanged while chip select is held. It takes effect on the edge at which `host_cs` is first sampled low, using the last address and data seen with chip select high.
- R4: Address map: 0 all-ones word (reads 0xFF), 1 and 2 transmit numbers A and B, 3 transmit message, 4 to 6 control words 1 to 3, 7 sequencer state (`seq_state`), 8 error status, 9 and 10 received numbers A and B, 11 received message, 12 clear error interrupt, 13 clear message interrupt, 14 clear power-fail interrupt, 15 revision (`REV_ID`, default 0x21). Addresses 1 to 6 read back the last value written, and `cfg_regs` carries them with address 1 in bits 7:0 and address 6 in bits 47:40.
- R5: Writes to addresses 0, 7 to 11 and 15 change no readable value and are still acknowledged. Addresses 12 to 14 read 0.
- R6: A pulse on `ev_rx` loads `ev_rx_cn0`, `ev_rx_cn1` and `ev_rx_msg` into addresses 9, 10 and 11. These keep their value until the next pulse.
- R7: After each cycle with `ev_rx`=1, `msg_irq` is 1 and `fifo_stb` is 1 for exactly that following cycle.
- R8: `pf_irq` becomes 1 after an `ev_rx` pulse whose message equals `PF_CODE` (default 0x3C). Other messages leave it unchanged.
- R9: Every nonzero `ev_err` sets `err_irq`, and its bits are ORed into the status register at address 8. The status register is cleared, together with `err_irq`, by a write to address 12.
- R10: A write of any data to address 12, 13 or 14 clears only its own interrupt (error, message, power-fail). If a set event arrives on the same edge as its clear, the set wins.
- R11: `cn_par[0]` and `cn_par[1]` give odd parity over transmit numbers A and B: each number together with its bit holds an odd count of ones.
- R12: After reset all writable registers, received registers, status, interrupts, `fifo_stb`, `host_ack` and `host_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Chip select, active high |
| host_rd | input | 1 | 1 = read, 0 = write |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data |
| wr_edge_sel | input | 1 | Write commit point: 0 at acknowledge, 1 at chip-select release |
| host_rdata | output | 8 | Read data, valid while `host_ack` is 1 |
| host_ack | output | 1 | Data acknowledge |
| seq_state | input | 8 | Sequencer state, shown at address 7 |
| ev_err | input | 8 | Error flags from the sequencer |
| ev_rx | input | 1 | Received-message pulse |
| ev_rx_cn0 | input | 8 | Received number A |
| ev_rx_cn1 | input | 8 | Received number B |
| ev_rx_msg | input | 8 | Received message word |
| cfg_regs | output | 48 | Writable registers 1 to 6 |
| cn_par | output | 2 | Odd parity of transmit numbers A and B |
| err_irq | output | 1 | Error interrupt |
| msg_irq | output | 1 | Message-received interrupt |
| pf_irq | output | 1 | Power-fail interrupt |
| fifo_stb | output | 1 | One-cycle strobe per received message |

## Verification
The bench watches `cfg_regs` through a chip-select-high window in both commit modes. A design that commits on the wrong edge shows the new value too early in release mode, or too late in acknowledge mode. It writes to every read-only location and reads them back, which catches a decoder that lets the all-ones, state or revision words be overwritten. It also clears the error interrupt on the same edge as a new error flag, where a design that gives priority to the clear loses the event. Random traffic compares parity, readback and the interrupt bits against a bench model. This catches even parity, a clear that hits the wrong interrupt, and a strobe that lasts longer than one cycle.

// File: rtl/hbank_pkg.sv
package hbank_pkg;
    localparam int unsigned HB_DW = 8;
    localparam int unsigned HB_AW = 4;

    typedef enum logic [HB_AW-1:0] {
        A_ONES    = 4'd0,
        A_CNA     = 4'd1,
        A_CNB     = 4'd2,
        A_TXMSG   = 4'd3,
        A_CFG1    = 4'd4,
        A_CFG2    = 4'd5,
        A_CFG3    = 4'd6,
        A_SEQST   = 4'd7,
        A_ERRST   = 4'd8,
        A_RXA     = 4'd9,
        A_RXB     = 4'd10,
        A_RXMSG   = 4'd11,
        A_CLR_ERR = 4'd12,
        A_CLR_MSG = 4'd13,
        A_CLR_PF  = 4'd14,
        A_REV     = 4'd15
    } hb_addr_e;

    localparam int unsigned HB_NRW = 6;   // writable words at addresses 1..6
    localparam int unsigned HB_NRX = 3;   // received words at addresses 9..11
endpackage

// File: rtl/hbank_parity.sv
module hbank_parity #(
    parameter int unsigned N  = 2,
    parameter int unsigned DW = 8
) (
    input  logic [N-1:0][DW-1:0] words,
    output logic [N-1:0]         par
);
    for (genvar g = 0; g < N; g++) begin : g_par
        // odd parity: the bit makes the total ones count odd
        assign par[g] = ~(^words[g]);
    end
endmodule

// File: rtl/hbank_host_if.sv
module hbank_host_if #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          rd,
    input  logic          edge_sel,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ack,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    typedef struct packed {
        logic          cs;
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } hif_t;

    hif_t st_d, st_q;
    logic commit_ack, commit_rel;

    always_comb begin
        st_d    = st_q;
        st_d.cs = cs;
        if (cs) begin
            st_d.rd   = rd;
            st_d.addr = addr;
            st_d.data = wdata;
        end
        commit_ack = !edge_sel && cs && !rd && !st_q.cs;
        commit_rel =  edge_sel && st_q.cs && !cs && !st_q.rd;
        wr_en      = commit_ack || commit_rel;
        wr_addr    = edge_sel ? st_q.addr : addr;
        wr_data    = edge_sel ? st_q.data : wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack = st_q.cs;
endmodule

// File: rtl/hbank_events.sv
module hbank_events #(
    parameter int unsigned    DW      = 8,
    parameter int unsigned    NRX     = 3,
    parameter logic [DW-1:0]  PF_CODE = 8'h3C
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ev_rx,
    input  logic [NRX-1:0][DW-1:0]  ev_words,
    input  logic [DW-1:0]           ev_err,
    input  logic                    clr_err,
    input  logic                    clr_msg,
    input  logic                    clr_pf,
    output logic [NRX-1:0][DW-1:0]  rx_words,
    output logic [DW-1:0]           err_status,
    output logic                    err_irq,
    output logic                    msg_irq,
    output logic                    pf_irq,
    output logic                    fifo_stb
);
    typedef struct packed {
        logic [NRX-1:0][DW-1:0] rx;
        logic [DW-1:0]          status;
        logic                   err;
        logic                   msg;
        logic                   pf;
        logic                   stb;
    } ev_t;

    ev_t ev_d, ev_q;
    logic pf_hit;

    always_comb begin
        ev_d   = ev_q;
        pf_hit = ev_rx && (ev_words[NRX-1] == PF_CODE);
        for (int i = 0; i < NRX; i++) begin
            if (ev_rx) ev_d.rx[i] = ev_words[i];
        end
        // clear first, then set: a simultaneous set survives
        ev_d.status = (clr_err ? '0 : ev_q.status) | ev_err;
        ev_d.err    = (ev_q.err && !clr_err) || (ev_err != '0);
        ev_d.msg    = (ev_q.msg && !clr_msg) || ev_rx;
        ev_d.pf     = (ev_q.pf  && !clr_pf)  || pf_hit;
        ev_d.stb    = ev_rx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign rx_words   = ev_q.rx;
    assign err_status = ev_q.status;
    assign err_irq    = ev_q.err;
    assign msg_irq    = ev_q.msg;
    assign pf_irq     = ev_q.pf;
    assign fifo_stb   = ev_q.stb;
endmodule

// File: rtl/hbank_regs.sv
module hbank_regs
    import hbank_pkg::*;
#(
    parameter logic [7:0] REV_ID  = 8'h21,
    parameter logic [7:0] PF_CODE = 8'h3C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_cs,
    input  logic        host_rd,
    input  logic [3:0]  host_addr,
    input  logic [7:0]  host_wdata,
    input  logic        wr_edge_sel,
    output logic [7:0]  host_rdata,
    output logic        host_ack,
    input  logic [7:0]  seq_state,
    input  logic [7:0]  ev_err,
    input  logic        ev_rx,
    input  logic [7:0]  ev_rx_cn0,
    input  logic [7:0]  ev_rx_cn1,
    input  logic [7:0]  ev_rx_msg,
    output logic [47:0] cfg_regs,
    output logic [1:0]  cn_par,
    output logic        err_irq,
    output logic        msg_irq,
    output logic        pf_irq,
    output logic        fifo_stb
);
    localparam int unsigned DW = HB_DW;
    localparam int unsigned AW = HB_AW;

    typedef struct packed {
        logic [HB_NRW-1:0][DW-1:0] rw;
        logic [DW-1:0]             rdata;
    } bank_t;

    bank_t bk_d, bk_q;

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          clr_err, clr_msg, clr_pf;
    logic [HB_NRX-1:0][DW-1:0] rx_words;
    logic [DW-1:0] err_status;
    logic [DW-1:0] rd_mux;

    hbank_host_if #(.AW(AW), .DW(DW)) u_hif (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs       (host_cs),
        .rd       (host_rd),
        .edge_sel (wr_edge_sel),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .ack      (host_ack),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    assign clr_err = wr_en && (wr_addr == A_CLR_ERR);
    assign clr_msg = wr_en && (wr_addr == A_CLR_MSG);
    assign clr_pf  = wr_en && (wr_addr == A_CLR_PF);

    hbank_events #(.DW(DW), .NRX(HB_NRX), .PF_CODE(PF_CODE)) u_ev (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_rx      (ev_rx),
        .ev_words   ({ev_rx_msg, ev_rx_cn1, ev_rx_cn0}),
        .ev_err     (ev_err),
        .clr_err    (clr_err),
        .clr_msg    (clr_msg),
        .clr_pf     (clr_pf),
        .rx_words   (rx_words),
        .err_status (err_status),
        .err_irq    (err_irq),
        .msg_irq    (msg_irq),
        .pf_irq     (pf_irq),
        .fifo_stb   (fifo_stb)
    );

    hbank_parity #(.N(2), .DW(DW)) u_par (
        .words ({bk_q.rw[1], bk_q.rw[0]}),
        .par   (cn_par)
    );

    always_comb begin
        unique case (hb_addr_e'(host_addr))
            A_ONES:  rd_mux = '1;
            A_CNA, A_CNB, A_TXMSG, A_CFG1, A_CFG2, A_CFG3:
                     rd_mux = bk_q.rw[host_addr - AW'(1)];
            A_SEQST: rd_mux = seq_state;
            A_ERRST: rd_mux = err_status;
            A_RXA:   rd_mux = rx_words[0];
            A_RXB:   rd_mux = rx_words[1];
            A_RXMSG: rd_mux = rx_words[2];
            A_REV:   rd_mux = REV_ID;
            default: rd_mux = '0;
        endcase
    end

    always_comb begin
        bk_d = bk_q;
        for (int i = 0; i < HB_NRW; i++) begin
            if (wr_en && (wr_addr == AW'(i + 1))) bk_d.rw[i] = wr_data;
        end
        if (host_cs) bk_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign host_rdata = bk_q.rdata;
    assign cfg_regs   = bk_q.rw;
endmodule

// File: rtl/hbank_regs_chk.sv
module hbank_regs_chk #(
    parameter logic [7:0] PF_CODE = 8'h3C
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_cs,
    input logic        host_ack,
    input logic        ev_rx,
    input logic [7:0]  ev_err,
    input logic [7:0]  ev_rx_msg,
    input logic [47:0] cfg_regs,
    input logic [1:0]  cn_par,
    input logic        err_irq,
    input logic        msg_irq,
    input logic        pf_irq,
    input logic        fifo_stb
);
    p_ack_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        host_cs |=> host_ack);
    p_ack_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !host_cs |=> !host_ack);
    p_msg_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx |=> (msg_irq && fifo_stb));
    p_stb_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_rx |=> !fifo_stb);
    p_pf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx && ev_rx_msg == PF_CODE) |=> pf_irq);
    p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_err != 8'h00) |=> err_irq);
    p_par_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cfg_regs[7:0], cn_par[0]}) % 2 == 1);
    p_par_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cfg_regs[15:8], cn_par[1]}) % 2 == 1);
endmodule

bind hbank_regs hbank_regs_chk #(.PF_CODE(PF_CODE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_cs   (host_cs),
    .host_ack  (host_ack),
    .ev_rx     (ev_rx),
    .ev_err    (ev_err),
    .ev_rx_msg (ev_rx_msg),
    .cfg_regs  (cfg_regs),
    .cn_par    (cn_par),
    .err_irq   (err_irq),
    .msg_irq   (msg_irq),
    .pf_irq    (pf_irq),
    .fifo_stb  (fifo_stb)
);

// File: tb/hbank_regs_tb.sv
module hbank_regs_tb_top;
    localparam logic [7:0] REV  = 8'h21;
    localparam logic [7:0] PFC  = 8'h3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs = 1'b0, host_rd = 1'b0, wr_edge_sel = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_ack;
    logic [7:0]  seq_state = 8'h5A;
    logic [7:0]  ev_err = '0;
    logic        ev_rx = 1'b0;
    logic [7:0]  ev_rx_cn0 = '0, ev_rx_cn1 = '0, ev_rx_msg = '0;
    logic [47:0] cfg_regs;
    logic [1:0]  cn_par;
    logic        err_irq, msg_irq, pf_irq, fifo_stb;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model
    logic [7:0] m_rw [6];
    logic [7:0] m_rx [3];
    logic [7:0] m_stat;
    logic       m_err, m_msg, m_pf;

    always #2.5 clk = ~clk;

    hbank_regs #(.REV_ID(REV), .PF_CODE(PFC)) dut_i (.*);

    function automatic logic oddp(input logic [7:0] v);
        return ~(^v);
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        case (a)
            4'd0:                          return 8'hFF;
            4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6: return m_rw[a - 4'd1];
            4'd7:                          return seq_state;
            4'd8:                          return m_stat;
            4'd9:                          return m_rx[0];
            4'd10:                         return m_rx[1];
            4'd11:                         return m_rx[2];
            4'd15:                         return REV;
            default:                       return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [3:0] a, input logic [7:0] d);
        if (a >= 4'd1 && a <= 4'd6) m_rw[a - 4'd1] = d;
        if (a == 4'd12) begin m_err = 1'b0; m_stat = 8'h00; end
        if (a == 4'd13) m_msg = 1'b0;
        if (a == 4'd14) m_pf  = 1'b0;
    endtask

    task automatic check_out(input string req);
        chk(req, {cfg_regs}, {m_rw[5], m_rw[4], m_rw[3], m_rw[2], m_rw[1], m_rw[0]});
        chk(req, {cn_par}, {oddp(m_rw[1]), oddp(m_rw[0])});
        chk(req, {err_irq, msg_irq, pf_irq}, {m_err, m_msg, m_pf});
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d, input logic sel);
        @(negedge clk);
        wr_edge_sel = sel; host_cs = 1'b1; host_rd = 1'b0; host_addr = a; host_wdata = d;
        @(negedge clk);
        chk("R1 ack rise", {host_ack}, 1'b1);
        host_cs = 1'b0;
        @(negedge clk);
        chk("R1 ack fall", {host_ack}, 1'b0);
        model_write(a, d);
        check_out("R4/R10 after write");
    endtask

    task automatic do_read(input logic [3:0] a, input string req);
        @(negedge clk);
        host_cs = 1'b1; host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        chk(req, {host_rdata}, exp_read(a));
        host_cs = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_event(input logic [7:0] err, input logic rx,
                            input logic [7:0] c0, input logic [7:0] c1, input logic [7:0] msg);
        @(negedge clk);
        ev_err = err; ev_rx = rx; ev_rx_cn0 = c0; ev_rx_cn1 = c1; ev_rx_msg = msg;
        @(negedge clk);
        ev_err = '0; ev_rx = 1'b0;
        m_stat = m_stat | err;
        if (err != 8'h00) m_err = 1'b1;
        if (rx) begin
            m_rx[0] = c0; m_rx[1] = c1; m_rx[2] = msg; m_msg = 1'b1;
            if (msg == PFC) m_pf = 1'b1;
        end
        chk("R7 fifo strobe", {fifo_stb}, rx);
        check_out("R6/R8/R9 after event");
        @(negedge clk);
        chk("R7 strobe one cycle", {fifo_stb}, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7031));
        foreach (m_rw[i]) m_rw[i] = 8'h00;
        foreach (m_rx[i]) m_rx[i] = 8'h00;
        m_stat = 8'h00; m_err = 1'b0; m_msg = 1'b0; m_pf = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 reset outputs", {host_ack, host_rdata, fifo_stb, err_irq, msg_irq, pf_irq},
            {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0});
        chk("R12 reset regs", {cfg_regs}, 48'h0);
        chk("R11 reset parity", {cn_par}, 2'b11);

        // R2: commit at acknowledge, visible while cs still high
        do_write(4'd1, 8'h00, 1'b0);
        @(negedge clk);
        wr_edge_sel = 1'b0; host_cs = 1'b1; host_rd = 1'b0; host_addr = 4'd1; host_wdata = 8'h03;
        @(negedge clk);
        chk("R2 value at ack", {cfg_regs[7:0]}, 8'h03);
        host_cs = 1'b0;
        @(negedge clk);
        model_write(4'd1, 8'h03);
        // R3: commit at release, unchanged while cs high
        @(negedge clk);
        wr_edge_sel = 1'b1; host_cs = 1'b1; host_rd = 1'b0; host_addr = 4'd1; host_wdata = 8'h01;
        @(negedge clk);
        chk("R3 held while cs", {cfg_regs[7:0]}, 8'h03);
        host_wdata = 8'h07;
        @(negedge clk);
        chk("R3 still held", {cfg_regs[7:0]}, 8'h03);
        host_cs = 1'b0; host_wdata = 8'hEE;
        @(negedge clk);
        chk("R3 value after release", {cfg_regs[7:0]}, 8'h07);
        chk("R11 parity after release", {cn_par[0]}, 1'b0);
        model_write(4'd1, 8'h07);

        // R5: read-only locations ignore writes
        for (int a = 0; a < 16; a++) begin
            if (a == 0 || (a >= 7 && a <= 11) || a == 15) begin
                do_write(4'(a), 8'h96, a[0]);
                do_read(4'(a), "R5 read-only after write");
            end
        end
        do_read(4'd12, "R5 clear location reads 0");
        do_read(4'd15, "R4 revision");
        do_read(4'd0, "R4 all-ones word");

        // R8: power-fail code and a non-matching one
        do_event(8'h00, 1'b1, 8'h11, 8'h22, 8'h3D);
        chk("R8 no pf on other message", {pf_irq}, 1'b0);
        do_event(8'h00, 1'b1, 8'hA1, 8'hB2, PFC);
        do_read(4'd11, "R6 received message");
        // R10: each clear hits only its own interrupt
        do_event(8'h30, 1'b0, 8'h00, 8'h00, 8'h00);
        do_write(4'd14, 8'h00, 1'b0);
        chk("R10 pf cleared alone", {err_irq, msg_irq, pf_irq}, 3'b110);
        do_write(4'd13, 8'h55, 1'b1);
        chk("R10 msg cleared alone", {err_irq, msg_irq, pf_irq}, 3'b100);

        // R10: set wins over a clear on the same edge
        @(negedge clk);
        wr_edge_sel = 1'b0; host_cs = 1'b1; host_rd = 1'b0; host_addr = 4'd12; host_wdata = 8'h00;
        ev_err = 8'h04;
        @(negedge clk);
        ev_err = 8'h00; host_cs = 1'b0;
        m_err = 1'b1; m_stat = 8'h04;
        chk("R10 set wins over clear", {err_irq}, 1'b1);
        @(negedge clk);
        do_read(4'd8, "R9 status after clear+set");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 4);
            if (op == 0) begin
                do_write(4'($urandom % 16), 8'($urandom), 1'($urandom));
            end else if (op == 1) begin
                do_read(4'($urandom % 16), "R4/R6/R9 random read");
            end else if (op == 2) begin
                do_event(($urandom % 3 == 0) ? 8'($urandom) : 8'h00, 1'($urandom),
                         8'($urandom), 8'($urandom),
                         ($urandom % 4 == 0) ? PFC : 8'($urandom));
            end else begin
                seq_state = 8'($urandom);
                do_read(4'd7, "R4 state read");
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule